// File: doc/BRIEF.md
# SAR converter serial port model (chip-select, four-wire, busy indicator)

This block is a synthesizable device-side model of a successive-approximation converter's serial port, for use as a partner when verifying host controllers. It watches three host-driven lines: a convert strobe, a data-input line used as chip select, and a serial clock. It drives one data-out line together with a separate output enable. A low enable stands for the line being released to high impedance, where an external pull-up would hold it high.

A conversion starts when the convert strobe rises while the data-input line is high. The model then releases data-out and counts a fixed number of system clock cycles. When the count ends it drives data-out low. With a pull-up on the line, that falling level is the completion interrupt for the host. Each later falling serial-clock edge presents one bit of a 16-bit word, most significant bit first. The word is captured from a parallel input when the conversion starts. The line is released on the clock edge after the last bit, or as soon as data-input goes high. While both convert and data-input are low, the port drives data-out low. If the convert strobe drops before readback is finished, the model aborts and raises a violation flag.

All three host lines are assumed to be synchronous to the system clock. The model reacts to a line change at the first rising system clock edge that sees it.

Top module: `sar_port_model`

## Requirements
- R1: While reset is high, sdo_oe, sdo and proto_err are all 0.
- R2: A 0-to-1 change of cnv while sdi is 1 starts a conversion, and sdo_oe is 0 from the next clock edge. A 0-to-1 change of cnv while sdi is 0 starts nothing, and sdo_oe stays 0 for as long as cnv stays high.
- R3: sdo_oe becomes 1 with sdo = 0 exactly CONV_CYCLES clock edges after the edge that started the conversion, provided sdi is 0 at that point.
- R4: Falling serial-clock edges during the conversion are ignored, so the first bit read afterwards is still the most significant bit.
- R5: After the conversion ends, falling serial-clock edges 1 to 16 put sample bits 15 down to 0 on sdo, in that order, with sdo_oe held at 1.
- R6: The 17th falling serial-clock edge after the conversion ends sets sdo_oe to 0.
- R7: Whenever sdi is 1, sdo_oe is 0 from the next clock edge, including in the middle of a readback.
- R8: With no conversion or readback in progress, cnv at 0 and sdi at 0 make the port drive sdo = 0 with sdo_oe = 1.
- R9: A 1-to-0 change of cnv during a conversion or a readback sets proto_err to 1 and sdo_oe to 0 at the next edge. proto_err stays at 1 until the next conversion starts, and a readback that finishes cleanly leaves it at 0.
- R10: The word shifted out is the value sample_in had on the clock edge that started the conversion. Later changes to sample_in have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Convert strobe from host |
| sdi | input | 1 | Host data-input line, acts as chip select |
| sck | input | 1 | Serial clock from host |
| sample_in | input | SAMPLE_W | Parallel conversion result to report |
| sdo | output | 1 | Serial data-out level |
| sdo_oe | output | 1 | 1 when sdo is driven, 0 when released (high impedance) |
| proto_err | output | 1 | Convert strobe dropped before readback finished |

## Verification
A wrong phase shows as sdo_oe at the wrong level within one clock edge of the next host line change. An idle port that keeps sdo released shows this as soon as cnv and sdi are low. A port stuck in readback shows it when the convert strobe rises again. An error in the conversion counter shows as sdo_oe rising one or more edges early or late against the exact CONV_CYCLES count. An error in the shift register or the bit counter shows as a wrong bit on the first falling serial-clock edge it affects, or as sdo_oe still high after the 17th edge.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    // Port phase: idle/acquisition, conversion timing, serial readback
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_READ = 2'd2
    } phase_e;

    // Data-out pin: drive enable plus driven level
    typedef struct packed {
        logic drive;
        logic level;
    } pin_drv_t;

    // Index of each watched line in the edge detector vector
    localparam int unsigned LN_CNV  = 0;
    localparam int unsigned LN_SCK  = 1;
    localparam int unsigned N_EDGE  = 2;

    function automatic pin_drv_t pin_release();
        return '{drive: 1'b0, level: 1'b0};
    endfunction

    function automatic pin_drv_t pin_drive(input logic lvl);
        return '{drive: 1'b1, level: lvl};
    endfunction

endpackage

// File: rtl/sar_port_edges.sv
module sar_port_edges #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    output logic [N-1:0] changed
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lines;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            assign changed[i] = lines[i] ^ prev[i];
        end
    endgenerate
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
    parameter int unsigned CYCLES = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic done
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic          busy;
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(CYCLES - 1);
        end else if (abort || done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] data,
    input  logic         shift,
    output logic         head,
    output logic         last
);
    localparam int unsigned NW = $clog2(W + 1);

    logic [W-1:0]  sr;
    logic [NW-1:0] sent;

    assign head = sr[W-1];
    assign last = (sent == NW'(W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            sent <= '0;
        end else if (load) begin
            sr   <= data;
            sent <= '0;
        end else if (shift) begin
            sr   <= {sr[W-2:0], 1'b0};
            sent <= sent + 1'b1;
        end
    end
endmodule

// File: rtl/sar_port_model.sv
module sar_port_model
    import sar_port_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 16,
    parameter int unsigned CONV_CYCLES = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnv,
    input  logic                sdi,
    input  logic                sck,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                proto_err
);
    logic [N_EDGE-1:0] chg;
    logic cnv_rise, cnv_fall, sck_fall;
    logic start, abort, shift, conv_done, head, last;

    phase_e   phase_q, phase_n;
    pin_drv_t pin_q, pin_n;
    logic     err_n;

    sar_port_edges #(.N(N_EDGE)) u_edges (
        .clk     (clk),
        .rst     (rst),
        .lines   ({sck, cnv}),
        .changed (chg)
    );

    assign cnv_rise = chg[LN_CNV] &  cnv;
    assign cnv_fall = chg[LN_CNV] & ~cnv;
    assign sck_fall = chg[LN_SCK] & ~sck;

    sar_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .abort (abort),
        .done  (conv_done)
    );

    sar_shift_out #(.W(SAMPLE_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .data  (sample_in),
        .shift (shift),
        .head  (head),
        .last  (last)
    );

    always_comb begin
        phase_n = phase_q;
        pin_n   = pin_q;
        err_n   = proto_err;
        start   = 1'b0;
        abort   = 1'b0;
        shift   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (cnv_rise && sdi) begin
                    start   = 1'b1;
                    err_n   = 1'b0;
                    phase_n = PH_CONV;
                    pin_n   = pin_release();
                end else if (!cnv && !sdi) begin
                    pin_n   = pin_drive(1'b0);
                end else begin
                    pin_n   = pin_release();
                end
            end
            PH_CONV: begin
                if (cnv_fall) begin
                    abort   = 1'b1;
                    err_n   = 1'b1;
                    phase_n = PH_IDLE;
                    pin_n   = pin_release();
                end else if (conv_done) begin
                    phase_n = sdi ? PH_IDLE : PH_READ;
                    pin_n   = sdi ? pin_release() : pin_drive(1'b0);
                end
            end
            PH_READ: begin
                if (cnv_fall) begin
                    err_n   = 1'b1;
                    phase_n = PH_IDLE;
                    pin_n   = pin_release();
                end else if (sdi) begin
                    phase_n = PH_IDLE;
                    pin_n   = pin_release();
                end else if (sck_fall) begin
                    if (last) begin
                        phase_n = PH_IDLE;
                        pin_n   = pin_release();
                    end else begin
                        shift   = 1'b1;
                        pin_n   = pin_drive(head);
                    end
                end
            end
            default: begin
                phase_n = PH_IDLE;
                pin_n   = pin_release();
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            pin_q     <= pin_release();
            proto_err <= 1'b0;
        end else begin
            phase_q   <= phase_n;
            pin_q     <= pin_n;
            proto_err <= err_n;
        end
    end

    assign sdo    = pin_q.level;
    assign sdo_oe = pin_q.drive;
endmodule

// File: rtl/sar_port_checker.sv
module sar_port_checker (
    input logic clk,
    input logic rst,
    input logic cnv,
    input logic sdi,
    input logic sdo,
    input logic sdo_oe,
    input logic proto_err
);
    // R2: a chip-select conversion start releases the line
    a_r2_start_releases: assert property (@(posedge clk) disable iff (rst)
        (cnv && !$past(cnv) && sdi) |=> !sdo_oe);

    // R3: the line always becomes driven at a low level first
    a_r3_done_drives_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> !sdo);

    // R7: data-input high always releases the line
    a_r7_sdi_releases: assert property (@(posedge clk) disable iff (rst)
        sdi |=> !sdo_oe);

    // R8: both lines held low gives a driven low level
    a_r8_idle_drives_low: assert property (@(posedge clk) disable iff (rst)
        (!cnv && !sdi && !$past(cnv)) |=> (sdo_oe && !sdo));

    // R9: the violation flag only rises after a convert fall
    a_r9_err_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(proto_err) |-> (!$past(cnv) && $past(cnv, 2)));
endmodule

bind sar_port_model sar_port_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnv       (cnv),
    .sdi       (sdi),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .proto_err (proto_err)
);

// File: tb/sim_sar_port_model.sv
`timescale 1ns/1ps
module sim_sar_port_model;
    localparam int unsigned W  = 16;
    localparam int unsigned CC = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnv = 1'b0;
    logic         sdi = 1'b0;
    logic         sck = 1'b0;
    logic [W-1:0] sample_in = '0;
    logic         sdo, sdo_oe, proto_err;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sar_port_model #(.SAMPLE_W(W), .CONV_CYCLES(CC)) u0 (
        .clk(clk), .rst(rst), .cnv(cnv), .sdi(sdi), .sck(sck),
        .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .proto_err(proto_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Start a chip-select conversion; returns one negedge after the start edge
    task automatic start_conv(input logic [W-1:0] v);
        sdi = 1'b1; cnv = 1'b0; tick();
        cnv = 1'b1; sample_in = v; tick();
    endtask

    // Wait out the conversion with serial-clock activity; returns after done edge
    task automatic wait_conv(output bit quiet);
        quiet = 1'b1;
        sdi = 1'b0;
        for (int i = 2; i <= int'(CC); i++) begin
            sck = i[0];
            tick();
            if (sdo_oe !== 1'b0) quiet = 1'b0;
        end
        sck = 1'b0;
        tick();
    endtask

    task automatic read_bits(input string req, input logic [W-1:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            sck = 1'b1; tick();
            sck = 1'b0; tick();
            check(req, $sformatf("bit %0d", W - 1 - k),
                  {30'd0, sdo_oe, sdo}, {30'd0, 1'b1, v[W-1-k]});
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; cnv = 1'b0; sdi = 1'b0;
        repeat (3) tick();
        check("R1", "pins in reset", {29'd0, sdo_oe, sdo, proto_err}, 32'd0);
        rst = 1'b0; tick();
        check("R8", "idle low after reset", {30'd0, sdo_oe, sdo}, 32'b10);
    endtask

    task automatic t_full(input logic [W-1:0] v, input bit change_sample);
        bit quiet;
        start_conv(v);
        check("R2", "released at start", {31'd0, sdo_oe}, 32'd0);
        if (change_sample) sample_in = ~v;
        wait_conv(quiet);
        check("R4", "quiet during conversion", {31'd0, quiet}, 32'd1);
        check("R3", "busy-done low", {30'd0, sdo_oe, sdo}, 32'b10);
        read_bits(change_sample ? "R10" : "R5", v, W);
        sck = 1'b1; tick(); sck = 1'b0; tick();
        check("R6", "released after 17th edge", {31'd0, sdo_oe}, 32'd0);
        check("R9", "no error on clean read", {31'd0, proto_err}, 32'd0);
        cnv = 1'b0; tick(); tick();
        check("R8", "idle low after read", {30'd0, sdo_oe, sdo}, 32'b10);
    endtask

    task automatic t_sdi_release(input logic [W-1:0] v);
        bit quiet;
        start_conv(v);
        wait_conv(quiet);
        read_bits("R5", v, 3);
        sdi = 1'b1; tick();
        check("R7", "sdi high releases", {31'd0, sdo_oe}, 32'd0);
        sck = 1'b1; tick(); sck = 1'b0; tick();
        check("R7", "stays released", {31'd0, sdo_oe}, 32'd0);
        sdi = 1'b0; cnv = 1'b0; tick(); tick();
        check("R8", "idle low again", {30'd0, sdo_oe, sdo}, 32'b10);
    endtask

    task automatic t_no_cs();
        bit quiet = 1'b1;
        sdi = 1'b0; cnv = 1'b0; tick();
        cnv = 1'b1; tick();
        check("R2", "no-cs rise releases", {31'd0, sdo_oe}, 32'd0);
        for (int i = 0; i < int'(CC) + 6; i++) begin
            sck = i[0]; tick();
            if (sdo_oe !== 1'b0) quiet = 1'b0;
        end
        sck = 1'b0;
        check("R2", "no conversion without cs", {31'd0, quiet}, 32'd1);
        cnv = 1'b0; tick(); tick();
    endtask

    task automatic t_abort_conv(input logic [W-1:0] v);
        start_conv(v);
        sdi = 1'b0;
        repeat (5) tick();
        cnv = 1'b0; tick();
        check("R9", "abort in conversion", {30'd0, proto_err, sdo_oe}, 32'b10);
        tick();
        check("R9", "error held in idle", {29'd0, proto_err, sdo_oe, sdo}, 32'b110);
        start_conv(v);
        check("R9", "error cleared at start", {31'd0, proto_err}, 32'd0);
        sdi = 1'b0; cnv = 1'b0; tick(); tick();
    endtask

    task automatic t_abort_read(input logic [W-1:0] v);
        bit quiet;
        start_conv(v);
        wait_conv(quiet);
        read_bits("R5", v, 4);
        cnv = 1'b0; tick();
        check("R9", "abort in readback", {30'd0, proto_err, sdo_oe}, 32'b10);
        tick();
    endtask

    initial begin
        t_reset();
        t_full(16'hA5C3, 1'b0);
        t_full(16'h0001, 1'b0);
        t_full(16'hFFFF, 1'b0);
        t_full(16'h3C5A, 1'b1);
        t_sdi_release(16'h8F10);
        t_no_cs();
        t_abort_conv(16'h1234);
        t_abort_read(16'hC00C);
        t_full(16'h7E81, 1'b0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule